// File: doc/BRIEF.md
# PHY Management Bus Master

This block lets a processor reach the registers of an external Ethernet PHY over the two-wire serial management bus. The bus has a clock line (MDC) driven by this block and one shared data line (MDIO). The block exposes two 16-bit registers on a simple single-cycle register port. The first is a command register. It holds the PHY address, the register address, a direction flag and a busy flag. The second is a data register. It holds the value to send on a write and receives the value returned on a read.

Software first loads the data register if the operation is a write. It then writes the command register with the busy flag set. Busy then reads back as one while the block shifts a complete frame out on MDIO. Busy clears by itself when the last bit is done. On a read, the PHY's answer is in the data register once busy has cleared. MDC is the system clock divided down. An input pin chooses between a normal and a larger divider, so that systems with a fast core clock still meet the PHY's MDC limit. The choice is sampled when each frame starts.

Top module: `mdio_master`

## Requirements
- R1: After reset both registers read zero, MDC is low and the MDIO output enable is low.
- R2: The command register reads back as PHY address at bits 15:11, register address at bits 10:6, zeros at bits 5:2, the write flag at bit 1 (1 = write, 0 = read) and busy at bit 0.
- R3: Writing the command register with bit 0 set while idle starts a frame of exactly 64 MDC cycles. Busy reads one from the next cycle until that frame ends, then clears by itself.
- R4: Every frame, sampled on MDC rising edges, begins with 32 ones, then start 01, then opcode 01 for a write or 10 for a read, then the 5-bit PHY address and the 5-bit register address, each most significant bit first.
- R5: In a write frame the block drives MDIO for all 64 bits. The turnaround is 10 and is followed by the 16 data-register bits, most significant first.
- R6: In a read frame the output enable is high for the first 46 bits and low from the turnaround (bit 46) to the end. The 16 bits sampled on the MDC rising edges of bits 48..63, most significant first, are in the data register once busy has cleared.
- R7: With the divider select low, the MDC period is 2*HALF_NORM system clocks. With it high, the period is 2*HALF_FAST. The select is sampled at frame start, and changing it mid-frame has no effect on that frame.
- R8: While busy is set, bus writes to either register are ignored. The command fields, the data register and the frame in flight are unchanged, and no second frame follows.
- R9: While idle, MDC stays low and the MDIO output enable stays low.
- R10: A command write with bit 0 clear stores the address and write fields but starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_sel | input | 1 | Register select: 0 command, 1 data |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data of the selected register |
| mdc_div_sel | input | 1 | 1 selects the larger MDC divider |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO line value from the pad |
| mdio_o | output | 1 | MDIO value driven to the pad |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
The bench runs a bit-level PHY model that records every bit on MDC rising edges and answers read frames. It compares whole 64-bit frames against a frame it builds from the command. A design that releases MDIO late or early on a read shows up as a driver conflict during the turnaround, and one that samples on the wrong edge or with an off-by-one bit count returns a shifted read word. Writes that arrive during a frame are aimed at both registers: a design that accepts them corrupts the write data already being sent or starts a second frame. The divider select is toggled mid-frame, and all-ones and all-zeros addresses and data are exercised, so a design that does not latch the select shows a mixed MDC period, and boundary handling of field edges is checked at both extremes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int DATA_W = 16;

  localparam int CMD_PHY_LSB  = 11;
  localparam int CMD_REG_LSB  = 6;
  localparam int CMD_WR_BIT   = 1;
  localparam int CMD_BUSY_BIT = 0;

  localparam logic [1:0] FRM_SOF   = 2'b01;
  localparam logic [1:0] FRM_OP_WR = 2'b01;
  localparam logic [1:0] FRM_OP_RD = 2'b10;
  localparam logic [1:0] FRM_TA_WR = 2'b10;

  typedef enum logic {
    SEL_CMD  = 1'b0,
    SEL_DATA = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic [PHY_AW-1:0] phy;
    logic [REG_AW-1:0] regad;
    logic              wr;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_NORM = 3,
  parameter int HALF_FAST = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div_sel,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF_MAX = (HALF_FAST > HALF_NORM) ? HALF_FAST : HALF_NORM;
  localparam int CW       = $clog2(HALF_MAX + 1);

  logic [CW-1:0] half_lim;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  generate
    if (HALF_NORM == HALF_FAST) begin : g_single
      assign half_lim = CW'(HALF_NORM - 1);
    end else begin : g_select
      assign half_lim = div_sel ? CW'(HALF_FAST - 1) : CW'(HALF_NORM - 1);
    end
  endgenerate

  assign tick = run && (cnt_q == half_lim);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = tick & ~mdc_q;
  assign fall_stb = tick & mdc_q;

  AST_MDC_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q); // R9
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              active,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam int HDR_W     = 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int FRAME_LEN = PRE_LEN + HDR_W;
  localparam int TA_POS    = PRE_LEN + 4 + PHY_AW + REG_AW;
  localparam int DATA_POS  = TA_POS + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  logic              active_q, active_d;
  logic              wr_q, wr_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [HDR_W-1:0]  hdr_q, hdr_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              last_bit;
  logic              in_pre;

  assign last_bit = (bit_q == CNT_W'(FRAME_LEN - 1));
  assign in_pre   = (bit_q < CNT_W'(PRE_LEN));

  always_comb begin
    active_d = active_q;
    wr_d     = wr_q;
    bit_d    = bit_q;
    hdr_d    = hdr_q;
    rx_d     = rx_q;
    done     = 1'b0;
    if (start && !active_q) begin
      active_d = 1'b1;
      wr_d     = cmd.wr;
      bit_d    = '0;
      rx_d     = '0;
      hdr_d    = {FRM_SOF, (cmd.wr ? FRM_OP_WR : FRM_OP_RD), cmd.phy, cmd.regad,
                  FRM_TA_WR, (cmd.wr ? wdata : {DATA_W{1'b1}})};
    end else if (active_q) begin
      if (rise_stb && !wr_q && (bit_q >= CNT_W'(DATA_POS))) begin
        rx_d = {rx_q[DATA_W-2:0], mdio_i};
      end
      if (fall_stb) begin
        if (last_bit) begin
          active_d = 1'b0;
          done     = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
          if (!in_pre) begin
            hdr_d = {hdr_q[HDR_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      bit_q    <= '0;
      hdr_q    <= '0;
      rx_q     <= '0;
    end else begin
      active_q <= active_d;
      wr_q     <= wr_d;
      bit_q    <= bit_d;
      hdr_q    <= hdr_d;
      rx_q     <= rx_d;
    end
  end

  assign active  = active_q;
  assign mdio_o  = active_q & (in_pre | hdr_q[HDR_W-1]);
  assign mdio_oe = active_q & (wr_q | (bit_q < CNT_W'(TA_POS)));
  assign rdata   = rx_q;

  AST_FRAME_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && fall_stb && last_bit |=> !active_q); // R3
  AST_WR_RX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && wr_q |=> $stable(rx_q)); // R5
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int PRE_LEN   = 32,
  parameter int HALF_NORM = 3,
  parameter int HALF_FAST = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_sel,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        mdc_div_sel,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mdio_cmd_t         cmd_q, cmd_d;
  logic              busy_q, busy_d;
  logic              div_q, div_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              cmd_wr_en, data_wr_en, start;
  logic              seq_active, seq_done;
  logic [DATA_W-1:0] seq_rdata;
  logic              rise_stb, fall_stb;
  logic              unused_cmd_bits;

  assign unused_cmd_bits = ^bus_wdata[CMD_REG_LSB-1:CMD_WR_BIT+1];

  assign cmd_wr_en  = bus_wr && !busy_q && (bus_sel == SEL_CMD);
  assign data_wr_en = bus_wr && !busy_q && (bus_sel == SEL_DATA);
  assign start      = cmd_wr_en && bus_wdata[CMD_BUSY_BIT];

  always_comb begin
    cmd_d  = cmd_q;
    busy_d = busy_q;
    div_d  = div_q;
    data_d = data_q;
    if (cmd_wr_en) begin
      cmd_d.phy   = bus_wdata[CMD_PHY_LSB +: PHY_AW];
      cmd_d.regad = bus_wdata[CMD_REG_LSB +: REG_AW];
      cmd_d.wr    = bus_wdata[CMD_WR_BIT];
    end
    if (start) begin
      busy_d = 1'b1;
      div_d  = mdc_div_sel;
    end else if (seq_done) begin
      busy_d = 1'b0;
    end
    if (data_wr_en) begin
      data_d = bus_wdata;
    end else if (seq_done && !cmd_q.wr) begin
      data_d = seq_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      div_q  <= 1'b0;
      data_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      busy_q <= busy_d;
      div_q  <= div_d;
      data_q <= data_d;
    end
  end

  assign bus_rdata = (bus_sel == SEL_CMD)
                   ? {cmd_q.phy, cmd_q.regad, 4'b0000, cmd_q.wr, busy_q}
                   : data_q;

  mdio_mdc_gen #(
    .HALF_NORM (HALF_NORM),
    .HALF_FAST (HALF_FAST)
  ) mdc_gen_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .run      (seq_active),
    .div_sel  (div_q),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_seq #(
    .PRE_LEN (PRE_LEN)
  ) frame_seq_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .start    (start),
    .cmd      (cmd_d),
    .wdata    (data_q),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .active   (seq_active),
    .done     (seq_done),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rdata    (seq_rdata)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !busy_q |-> !mdc && !mdio_oe); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_q)
    start |=> busy_q); // R3
  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_sync_q)
    busy_q && bus_wr |=> $stable(cmd_q)); // R8
  AST_WDATA_LOCKED: assert property (@(posedge clk) disable iff (!rst_sync_q)
    busy_q && bus_wr && cmd_q.wr |=> $stable(data_q)); // R8
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam int HALF_NORM = 3;
  localparam int HALF_FAST = 6;
  localparam int CLK_NS    = 8;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_sel;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        mdc_div_sel;
  logic        mdc;
  logic        mdio_i;
  logic        mdio_o;
  logic        mdio_oe;

  int checks;
  int errors;

  mdio_master #(
    .PRE_LEN   (32),
    .HALF_NORM (HALF_NORM),
    .HALF_FAST (HALF_FAST)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_sel     (bus_sel),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .mdc_div_sel (mdc_div_sel),
    .mdc         (mdc),
    .mdio_i      (mdio_i),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  // PHY model: records line bits on MDC rise, answers reads after the turnaround
  logic [63:0] cap;
  int          rsp_cnt;
  logic        rsp_drive;
  logic [15:0] rsp_word;
  logic        op_rd;
  logic        ta_viol;
  time         last_rise;
  int          per_min;
  int          per_max;

  assign mdio_i = mdio_oe ? mdio_o : rsp_drive;

  initial begin
    rsp_drive = 1'b1;
    rsp_cnt   = 0;
    cap       = '0;
    op_rd     = 1'b0;
    ta_viol   = 1'b0;
    last_rise = 0;
    per_min   = 1000000;
    per_max   = 0;
    rsp_word  = '0;
  end

  always @(posedge mdc) begin
    if (rsp_cnt > 0) begin
      if (int'($time - last_rise) < per_min) per_min = int'($time - last_rise);
      if (int'($time - last_rise) > per_max) per_max = int'($time - last_rise);
    end
    last_rise = $time;
    if (op_rd && rsp_cnt >= 46 && mdio_oe) ta_viol = 1'b1;
    if (op_rd && rsp_cnt < 46 && !mdio_oe) ta_viol = 1'b1;
    if (!op_rd && !mdio_oe) ta_viol = 1'b1;
    cap = {cap[62:0], mdio_i};
    rsp_cnt = rsp_cnt + 1;
  end

  always @(negedge mdc) begin
    if (op_rd && rsp_cnt == 47) rsp_drive = 1'b0;
    else if (op_rd && rsp_cnt >= 48 && rsp_cnt <= 63) rsp_drive = rsp_word[63-rsp_cnt];
    else rsp_drive = 1'b1;
  end

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
  endfunction

  function automatic logic [15:0] cmd_word(input logic [4:0] phy, input logic [4:0] rg,
                                           input logic wr, input logic go);
    return {phy, rg, 4'b0000, wr, go};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    bus_sel   = sel;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic sel, output logic [15:0] d);
    @(negedge clk);
    bus_sel = sel;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle(output logic ok);
    logic [15:0] r;
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      bus_read(1'b0, r);
      if (!r[0]) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic start_op(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] wd, input logic div);
    logic [15:0] r;
    if (wr) bus_write(1'b1, wd);
    mdc_div_sel = div;
    op_rd       = !wr;
    rsp_cnt     = 0;
    cap         = '0;
    ta_viol     = 1'b0;
    per_min     = 1000000;
    per_max     = 0;
    bus_write(1'b0, cmd_word(phy, rg, wr, 1'b1));
    bus_read(1'b0, r);
    chk(r == cmd_word(phy, rg, wr, 1'b1), "R2/R3 busy readback", 64'(r),
        64'(cmd_word(phy, rg, wr, 1'b1)));
  endtask

  task automatic finish_op(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic div);
    logic        ok;
    logic [15:0] r;
    logic [63:0] ef;
    int          eper;
    wait_idle(ok);
    chk(ok, "R3 busy clears", 64'(ok), 64'd1);
    chk(rsp_cnt == 64, "R3 frame length", 64'(rsp_cnt), 64'd64);
    ef = exp_frame(wr, phy, rg, wr ? wd : rsp_word);
    chk(cap[63:18] == ef[63:18], "R4 frame header", cap, ef);
    if (wr) begin
      chk(cap[17:0] == ef[17:0], "R5 turnaround and data", cap, ef);
      chk(!ta_viol, "R5 driven whole frame", 64'(ta_viol), 64'd0);
    end else begin
      bus_read(1'b1, r);
      chk(r == rsp_word, "R6 read data", 64'(r), 64'(rsp_word));
      chk(!ta_viol, "R6 release at turnaround", 64'(ta_viol), 64'd0);
    end
    eper = 2 * (div ? HALF_FAST : HALF_NORM) * CLK_NS;
    chk(per_min == eper && per_max == eper, "R7 MDC period", 64'(per_max), 64'(eper));
    chk(!mdc && !mdio_oe, "R9 idle quiet", {mdc, mdio_oe}, 64'd0);
  endtask

  task automatic do_op(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic div);
    start_op(wr, phy, rg, wd, div);
    finish_op(wr, phy, rg, wd, div);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] r;
    logic        ok;
    int          seed;
    int          cnt0;
    checks      = 0;
    errors      = 0;
    seed        = 1234;
    void'($urandom(seed));
    bus_wr      = 1'b0;
    bus_sel     = 1'b0;
    bus_wdata   = '0;
    mdc_div_sel = 1'b0;
    rst_n       = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(1'b0, r);
    chk(r == 16'h0, "R1 command reset", 64'(r), 64'd0);
    bus_read(1'b1, r);
    chk(r == 16'h0, "R1 data reset", 64'(r), 64'd0);
    chk(!mdc && !mdio_oe, "R1 bus idle", {mdc, mdio_oe}, 64'd0);

    // R10 command without start bit
    rsp_cnt = 0;
    bus_write(1'b0, cmd_word(5'd3, 5'd7, 1'b1, 1'b0));
    bus_read(1'b0, r);
    chk(r == cmd_word(5'd3, 5'd7, 1'b1, 1'b0), "R10/R2 fields stored", 64'(r),
        64'(cmd_word(5'd3, 5'd7, 1'b1, 1'b0)));
    repeat (100) @(negedge clk);
    chk(rsp_cnt == 0 && !mdc, "R10 no frame started", 64'(rsp_cnt), 64'd0);

    // directed extremes
    do_op(1'b1, 5'd31, 5'd31, 16'hFFFF, 1'b0);
    do_op(1'b1, 5'd0, 5'd0, 16'h0000, 1'b1);
    rsp_word = 16'h0000;
    do_op(1'b0, 5'd31, 5'd0, 16'h0, 1'b0);
    rsp_word = 16'hFFFF;
    do_op(1'b0, 5'd0, 5'd31, 16'h0, 1'b1);
    rsp_word = 16'h8001;
    do_op(1'b0, 5'd21, 5'd10, 16'h0, 1'b0);

    // R8 writes during a write frame are ignored
    start_op(1'b1, 5'd5, 5'd9, 16'hA5A5, 1'b0);
    repeat (100) @(negedge clk);
    bus_write(1'b1, 16'h1234);
    bus_write(1'b0, cmd_word(5'd17, 5'd2, 1'b0, 1'b1));
    finish_op(1'b1, 5'd5, 5'd9, 16'hA5A5, 1'b0);
    bus_read(1'b1, r);
    chk(r == 16'hA5A5, "R8 data unchanged", 64'(r), 64'hA5A5);
    bus_read(1'b0, r);
    chk(r == cmd_word(5'd5, 5'd9, 1'b1, 1'b0), "R8 command unchanged", 64'(r),
        64'(cmd_word(5'd5, 5'd9, 1'b1, 1'b0)));
    cnt0 = rsp_cnt;
    repeat (200) @(negedge clk);
    chk(rsp_cnt == cnt0 && !mdc, "R8 no second frame", 64'(rsp_cnt), 64'(cnt0));

    // R7 divider select latched at frame start
    start_op(1'b1, 5'd12, 5'd3, 16'h5A3C, 1'b0);
    repeat (60) @(negedge clk);
    mdc_div_sel = 1'b1;
    finish_op(1'b1, 5'd12, 5'd3, 16'h5A3C, 1'b0);
    start_op(1'b0, 5'd1, 5'd4, 16'h0, 1'b1);
    repeat (60) @(negedge clk);
    mdc_div_sel = 1'b0;
    finish_op(1'b0, 5'd1, 5'd4, 16'h0, 1'b1);

    // constrained random operations
    for (int n = 0; n < 16; n++) begin
      logic        wr;
      logic [4:0]  phy;
      logic [4:0]  rg;
      logic [15:0] wd;
      logic        dv;
      wr       = 1'($urandom);
      phy      = 5'($urandom);
      rg       = 5'($urandom);
      wd       = 16'($urandom);
      dv       = 1'($urandom);
      rsp_word = 16'($urandom);
      do_op(wr, phy, rg, wd, dv);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule